// File: doc/BRIEF.md
# Paced Single-Byte DMA Request Generator

This block spaces out DMA requests for a serial transmitter so that bytes leave at fixed intervals with a pause between them. It has two identical, independent channels. Each channel holds a reloading down-counter and a request flag. Each time the counter completes a period, it raises a one-cycle tick. The tick sets the channel's request flag only while the transmit FIFO reports free space. When the FIFO is too full, the trigger is dropped rather than queued, so the FIFO cannot overrun.

The DMA engine moves one byte per request. Its acknowledge lowers the flag. Software can also drop a flag at any time by writing a one to a clear bit that is not stored. A small word-addressed register port provides the period value and the run bit of each channel. A typical transfer list ends with a write that clears the run bit, so the timer halts after the last byte. Because setting the run bit reloads the counter, the next block then starts with the same spacing as the first.

Top module: `paced_dma_req`

## Requirements
- R1: After reset, every request and tick output is 0, and every register reads 0.
- R2: Register address is {channel, select}. Select 0 is the period word, which reads back as written. Select 1 is control: bit 0 is the run bit (read/write), bit 1 is the clear bit (always reads 0), and bit 2 is a read-only copy of the channel's request flag.
- R3: Writing run=1 to a stopped channel with period P loads the counter. The tick is then high for exactly one cycle every P cycles. The first tick is in the cycle after the (P-1)th clock edge that follows the write edge.
- R4: A tick sets the request flag at the next edge only if the channel's fifo_room input is 1 in the tick cycle. Otherwise the flag does not change. Without a tick, acknowledge or clear, the flag holds its value.
- R5: A dma_ack high at an edge leaves the request flag 0 after that edge.
- R6: Writing control with bit 1 = 1 clears that channel's flag at the write edge. Writing with bit 1 = 0 leaves the flag unchanged.
- R7: When a set condition and an acknowledge or clear meet at the same edge, the flag ends up 0.
- R8: While the run bit is 0, the channel produces no tick and its flag is not set.
- R9: A period word of 0 behaves as 1, and the channel then ticks every cycle.
- R10: The channels are independent: a write, acknowledge or tick on one channel never changes the other channel's outputs.
- R11: A period word written while the channel is running takes effect at the next reload. The interval that is already counting is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | $clog2(NUM_CH)+1 | Register address {channel, select} |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data for reg_addr (combinational) |
| fifo_room | input | NUM_CH | Per channel: the transmit FIFO is at or below its half-full threshold |
| dma_ack | input | NUM_CH | Per channel: the DMA single-byte transfer is acknowledged |
| dma_req | output | NUM_CH | Per channel: the paced request flag |
| tick | output | NUM_CH | Per channel: the one-cycle timer expiry pulse |

## Verification
An internal counter that is wrong by even one count shows up on the tick output within a single period. The tick then lands a cycle early or late, or the pulse stretches, and the per-clock reference comparison catches it at the first misplaced edge. A corrupted request flag shows up on dma_req, and in the control readback, in the cycle after the faulty edge. This happens when the flag is set without FIFO room, survives an acknowledge or a clear, or loses the priority of the clear. The directed sequences place acknowledges exactly on tick cycles and change the period while a channel runs, so errors in priority and reload timing appear within a few cycles.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
  typedef enum logic {
    SEL_PERIOD = 1'b0,
    SEL_CTRL   = 1'b1
  } reg_sel_e;

  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_CLR_BIT = 1;
  localparam int unsigned CTRL_REQ_BIT = 2;
endpackage

// File: rtl/pdr_rst_sync.sv
module pdr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pdr_regs.sv
module pdr_regs #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned AW     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [NUM_CH-1:0] req_sts,
  output logic [CNT_W-1:0] period [NUM_CH],
  output logic [NUM_CH-1:0] run,
  output logic [NUM_CH-1:0] start,
  output logic [NUM_CH-1:0] sw_clr,
  output logic [CNT_W-1:0] rdata
);
  import pdr_pkg::*;

  localparam int unsigned CH_W = AW - 1;

  logic [CH_W-1:0] ch_sel;
  reg_sel_e        sel;

  assign ch_sel = addr[AW-1:1];
  assign sel    = reg_sel_e'(addr[0]);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic             hit;
    logic             wr_period, wr_ctrl;
    logic             period_en, run_en;
    logic [CNT_W-1:0] period_q, period_nxt;
    logic             run_q, run_nxt;

    assign hit       = we && (ch_sel == CH_W'(g));
    assign wr_period = hit && (sel == SEL_PERIOD);
    assign wr_ctrl   = hit && (sel == SEL_CTRL);
    assign period_en = wr_period;
    assign run_en    = wr_ctrl;

    always_comb begin
      period_nxt = wdata;
      run_nxt    = wdata[CTRL_RUN_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        period_q <= '0;
        run_q    <= 1'b0;
      end else begin
        if (period_en) period_q <= period_nxt;
        if (run_en)    run_q    <= run_nxt;
      end
    end

    assign period[g] = period_q;
    assign run[g]    = run_q;
    assign start[g]  = wr_ctrl && wdata[CTRL_RUN_BIT] && !run_q;
    assign sw_clr[g] = wr_ctrl && wdata[CTRL_CLR_BIT];
  end

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (ch_sel == CH_W'(c)) begin
        if (sel == SEL_PERIOD) begin
          rdata = period[c];
        end else begin
          rdata[CTRL_RUN_BIT] = run[c];
          rdata[CTRL_REQ_BIT] = req_sts[c];
        end
      end
    end
  end
endmodule

// File: rtl/pdr_timer.sv
module pdr_timer #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             start,
  input  logic [CNT_W-1:0] period,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt, reload;
  logic             cnt_en;

  assign reload = (period == '0) ? CNT_W'(1) : period;
  assign tick   = run && (cnt_q == CNT_W'(1));
  assign cnt_en = start || run;

  always_comb begin
    if (start)     cnt_nxt = reload;
    else if (tick) cnt_nxt = reload;
    else           cnt_nxt = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/pdr_req_flag.sv
module pdr_req_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic req
);
  logic req_q, req_nxt;

  always_comb begin
    if (clr)      req_nxt = 1'b0;
    else if (set) req_nxt = 1'b1;
    else          req_nxt = req_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_nxt;
  end

  assign req = req_q;
endmodule

// File: rtl/paced_dma_req.sv
module paced_dma_req #(
  parameter int unsigned NUM_CH = 2,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic [$clog2(NUM_CH):0]    reg_addr,
  input  logic [CNT_W-1:0]           reg_wdata,
  output logic [CNT_W-1:0]           reg_rdata,
  input  logic [NUM_CH-1:0]          fifo_room,
  input  logic [NUM_CH-1:0]          dma_ack,
  output logic [NUM_CH-1:0]          dma_req,
  output logic [NUM_CH-1:0]          tick
);
  localparam int unsigned AW = $clog2(NUM_CH) + 1;

  logic                 rst_sync_n;
  logic [CNT_W-1:0]     period [NUM_CH];
  logic [NUM_CH-1:0]    run_en, start, sw_clr;

  pdr_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pdr_regs #(.NUM_CH(NUM_CH), .CNT_W(CNT_W), .AW(AW)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we      (reg_we),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .req_sts (dma_req),
    .period  (period),
    .run     (run_en),
    .start   (start),
    .sw_clr  (sw_clr),
    .rdata   (reg_rdata)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pdr_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .run    (run_en[g]),
      .start  (start[g]),
      .period (period[g]),
      .tick   (tick[g])
    );

    pdr_req_flag u_flag (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .set   (tick[g] && fifo_room[g]),
      .clr   (dma_ack[g] || sw_clr[g]),
      .req   (dma_req[g])
    );
  end
endmodule

// File: rtl/pdr_checker.sv
module pdr_checker #(
  parameter int unsigned NUM_CH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] tick,
  input logic [NUM_CH-1:0] dma_req,
  input logic [NUM_CH-1:0] dma_ack,
  input logic [NUM_CH-1:0] fifo_room,
  input logic [NUM_CH-1:0] run,
  input logic [NUM_CH-1:0] sw_clr
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    assert_set_needs_room_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_req[g]) |-> $past(tick[g] && fifo_room[g]));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick[g] && !dma_ack[g] && !sw_clr[g]) |=> $stable(dma_req[g]));

    assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dma_ack[g] |=> !dma_req[g]);

    assert_swclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sw_clr[g] |=> !dma_req[g]);

    assert_clear_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[g] && fifo_room[g] && (dma_ack[g] || sw_clr[g])) |=> !dma_req[g]);

    assert_stopped_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run[g] |-> !tick[g]);
  end
endmodule

bind paced_dma_req pdr_checker #(.NUM_CH(NUM_CH)) u_pdr_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .tick      (tick),
  .dma_req   (dma_req),
  .dma_ack   (dma_ack),
  .fifo_room (fifo_room),
  .run       (run_en),
  .sw_clr    (sw_clr)
);

// File: tb/paced_dma_req_test.sv
module paced_dma_req_test;
  localparam int NCH = 2;
  localparam int W   = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           reg_we;
  logic [1:0]     reg_addr;
  logic [W-1:0]   reg_wdata;
  logic [W-1:0]   reg_rdata;
  logic [NCH-1:0] fifo_room, dma_ack, dma_req, tick;

  int checks = 0;
  int errors = 0;
  bit cmp_on = 0;
  bit done   = 0;

  // behavioural reference: remaining cycles to next pulse, period, run, flag
  int m_left [NCH];
  int m_per  [NCH];
  bit m_run  [NCH];
  bit m_req  [NCH];

  paced_dma_req #(.NUM_CH(NCH), .CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_room(fifo_room),
    .dma_ack(dma_ack), .dma_req(dma_req), .tick(tick)
  );

  always #4 clk = ~clk;

  function automatic bit m_tick(int c);
    return m_run[c] && (m_left[c] == 1);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_left[c] = 0; m_per[c] = 0; m_run[c] = 0; m_req[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++) begin
        bit fire, kill, wctl, wper, nrun;
        int eff;
        fire = m_tick(c) && fifo_room[c];
        wctl = reg_we && (reg_addr == 2'(2*c+1));
        wper = reg_we && (reg_addr == 2'(2*c));
        kill = dma_ack[c] || (wctl && reg_wdata[1]);
        eff  = (m_per[c] == 0) ? 1 : m_per[c];
        if (kill)      m_req[c] = 0;
        else if (fire) m_req[c] = 1;
        nrun = wctl ? reg_wdata[0] : m_run[c];
        if (wctl && reg_wdata[0] && !m_run[c]) m_left[c] = eff;
        else if (m_run[c]) m_left[c] = (m_left[c] == 1) ? eff : m_left[c] - 1;
        m_run[c] = nrun;
        if (wper) m_per[c] = int'(reg_wdata);
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      for (int c = 0; c < NCH; c++) begin
        chk("R3 tick vs model", tick[c], m_tick(c));
        chk("R4 req vs model", dma_req[c], m_req[c]);
      end
    end
  end

  task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [W-1:0] exp, input string tag);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wait_tick(input int c);
    for (int i = 0; i < 60 && !tick[c]; i++) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    fifo_room = '0; dma_ack = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_on = 1;

    // R1 reset state
    chk("R1 req", dma_req, 0);
    chk("R1 tick", tick, 0);
    rd(2'd0, 16'h0, "R1 period0");
    rd(2'd1, 16'h0, "R1 ctrl0");

    // R2 readback
    wr(2'd0, 16'd5);
    rd(2'd0, 16'd5, "R2 period0");
    wr(2'd2, 16'h1234);
    rd(2'd2, 16'h1234, "R2 period1");
    fifo_room = 2'b11;

    // R3 first tick one period after start
    wr(2'd1, 16'h0001);
    repeat (4) @(negedge clk);
    chk("R3 first tick", tick[0], 1'b1);
    @(negedge clk);
    chk("R3 pulse one cycle", tick[0], 1'b0);
    chk("R4 set with room", dma_req[0], 1'b1);
    rd(2'd1, 16'h0005, "R2 ctrl mirrors req");

    // R5 acknowledge
    dma_ack[0] = 1'b1;
    @(negedge clk);
    dma_ack[0] = 1'b0;
    chk("R5 ack clears", dma_req[0], 1'b0);

    // R4 no room: ticks dropped
    fifo_room[0] = 1'b0;
    repeat (12) @(negedge clk);
    chk("R4 dropped without room", dma_req[0], 1'b0);
    fifo_room[0] = 1'b1;

    // R6 write-one clear
    repeat (6) @(negedge clk);
    chk("R6 precondition", dma_req[0], 1'b1);
    wr(2'd1, 16'h0001);
    chk("R6 zero write no effect", dma_req[0], 1'b1);
    wr(2'd1, 16'h0003);
    chk("R6 one write clears", dma_req[0], 1'b0);
    rd(2'd1, 16'h0001, "R2 clear bit reads 0");

    // R7 clear wins over set
    wait_tick(0);
    chk("R7 precondition", dma_req[0], 1'b0);
    dma_ack[0] = 1'b1;
    @(negedge clk);
    dma_ack[0] = 1'b0;
    chk("R7 ack beats tick", dma_req[0], 1'b0);

    // R10 independence
    repeat (6) @(negedge clk);
    chk("R10 ch0 req set", dma_req[0], 1'b1);
    wr(2'd3, 16'h0002);
    chk("R10 ch1 clear leaves ch0", dma_req[0], 1'b1);
    chk("R10 ch1 idle", tick[1], 1'b0);

    // R8 stop
    wr(2'd1, 16'h0000);
    n = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (tick[0]) n++;
    end
    chk("R8 no ticks while stopped", n, 0);
    chk("R8 req held while stopped", dma_req[0], 1'b1);

    // R9 period zero
    wr(2'd2, 16'h0000);
    wr(2'd3, 16'h0001);
    n = 0;
    for (int i = 0; i < 10; i++) begin
      if (tick[1]) n++;
      @(negedge clk);
    end
    chk("R9 tick every cycle", n, 10);
    chk("R10 ch0 unaffected", dma_req[0], 1'b1);

    // R11 period change while running
    wr(2'd0, 16'd3);
    wr(2'd1, 16'h0001);
    wait_tick(0);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick[0] && n < 60);
    chk("R11 old period", n, 3);
    wr(2'd0, 16'd7);
    wait_tick(0);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick[0] && n < 60);
    chk("R11 new period at reload", n, 7);

    repeat (3) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule